// File: doc/BRIEF.md
# Table Indirect Jump Sequencer

This block carries out the memory side of a table-indexed indirect jump for a small 16-bit controller core. The decoder hands it three operands when it pulses `start`: the register address of a word that holds the start of a jump table, the register address of a word that points to an index byte, and a 7-bit immediate mask. The block then reads everything it needs over a byte-wide synchronous read port and returns the new program counter together with a one-cycle `done` strobe.

Operand register addresses go through register-window translation before they are used. The pointer held in the index word is used exactly as read, with no translation. The index byte is ANDed with the mask to give an offset from 0 to 127. The offset is doubled so that table entries stay word aligned and is added to the table start. The new PC is the 16-bit little-endian word stored at that entry, not the entry address. Processor flags are not touched by this block.

Top module: `tbl_jump_seq`

## Requirements
- R1: After reset `busy`, `done` and `mem_rd` are low, and `mem_rd` stays low whenever `busy` is low.
- R2: A sequence makes exactly seven byte reads, in this order: table-start word low byte, then high byte, then index-pointer word low byte, then high byte, then the index byte, then destination word low byte, then high byte. Each read request is a single-cycle `mem_rd` pulse.
- R3: An operand register address `op` maps to physical address `{8'h00, op}` when `win_en` is low or `op` < 0x80. When `win_en` is high and `op` >= 0x80, it maps to `win_base + (op - 0x80)`. The high byte of a word register is read at the mapped address plus one.
- R4: The index byte is read at the 16-bit pointer value exactly as read from memory. No window translation is applied to that pointer, even when `win_en` is high.
- R5: offset = index_byte[6:0] AND mask. Bit 7 of the index byte never affects the result.
- R6: The destination address is table_start + 2*offset.
- R7: `new_pc` is `{byte at dest+1, byte at dest}` (little-endian), and it is presented together with `done`.
- R8: Every 16-bit address sum (mapped operand, operand+1, destination, destination+1) wraps modulo 2^16.
- R9: `busy` is high from the cycle after `start` is sampled until `done`. `done` is a single-cycle pulse during which `busy` is already low. With a memory that answers each read L cycles after sampling it, `done` is first high after 7*(L+1) clock edges following the edge that sampled `start`.
- R10: A `start` pulse while `busy` is high is ignored. The operands and the result of the running sequence are unchanged, and no second sequence follows.
- R11: A read value is taken only when `mem_rvalid` is high. No new request is issued while a read is outstanding, so slower memories give the same result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a jump sequence (sampled when idle) |
| base_op | input | 8 | Register address of the table-start word |
| idx_op | input | 8 | Register address of the index-pointer word |
| mask | input | 7 | Immediate mask for the index byte |
| win_en | input | 1 | Register windowing active |
| win_base | input | 16 | Physical base of the register window |
| mem_rd | output | 1 | Single-cycle byte read request |
| mem_addr | output | 16 | Read address, valid with `mem_rd` |
| mem_rdata | input | 8 | Read data, valid with `mem_rvalid` |
| mem_rvalid | input | 1 | Read data valid |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle strobe, new PC valid |
| new_pc | output | 16 | Jump target read from the table |

## Verification
Each read request is due one cycle after the previous read value was taken. The result and `done` are due exactly 7*(L+1) edges after the edge that samples `start`. The bench therefore counts falling edges from the start pulse and compares the count with that figure, rather than polling for the strobe without a bound. Read addresses are logged at rising edges and compared in order with the seven addresses computed from the requirement formulas. All ports are driven and sampled on the falling edge, half a cycle from any register update. Runs alternate memory latencies of one to three cycles, so the waits on `mem_rvalid` are exercised under each spacing.

// File: rtl/tij_pkg.sv
package tij_pkg;
  localparam int DW        = 8;
  localparam int NUM_READS = 7;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } seq_state_e;

  typedef enum logic [2:0] {
    RD_TBL_LO  = 3'd0,
    RD_TBL_HI  = 3'd1,
    RD_PTR_LO  = 3'd2,
    RD_PTR_HI  = 3'd3,
    RD_IDX     = 3'd4,
    RD_DEST_LO = 3'd5,
    RD_DEST_HI = 3'd6
  } read_step_e;
endpackage

// File: rtl/tij_window.sv
module tij_window #(
  parameter int          AW     = 16,
  parameter int          OPW    = 8,
  parameter logic [7:0]  WIN_LO = 8'h80
) (
  input  logic [OPW-1:0] op,
  input  logic           win_en,
  input  logic [AW-1:0]  win_base,
  output logic [AW-1:0]  phys
);
  localparam logic [OPW-1:0] LO = OPW'(WIN_LO);

  logic           in_window;
  logic [OPW-1:0] rel;

  always_comb begin
    in_window = win_en && (op >= LO);
    rel       = op - LO;
    if (in_window) phys = win_base + AW'(rel);
    else           phys = AW'(op);
  end
endmodule

// File: rtl/tij_addr_calc.sv
module tij_addr_calc #(
  parameter int AW = 16,
  parameter int MW = 7
) (
  input  logic [AW-1:0] tbl_start,
  input  logic [7:0]    idx_byte,
  input  logic [MW-1:0] mask,
  output logic [AW-1:0] dest
);
  logic [MW-1:0] offset;

  always_comb begin
    offset = idx_byte[MW-1:0] & mask;
    dest   = tbl_start + (AW'(offset) << 1);
  end
endmodule

// File: rtl/tbl_jump_seq.sv
module tbl_jump_seq
  import tij_pkg::*;
#(
  parameter int         AW     = 16,
  parameter int         OPW    = 8,
  parameter int         MW     = 7,
  parameter logic [7:0] WIN_LO = 8'h80
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [OPW-1:0] base_op,
  input  logic [OPW-1:0] idx_op,
  input  logic [MW-1:0]  mask,
  input  logic           win_en,
  input  logic [AW-1:0]  win_base,
  output logic           mem_rd,
  output logic [AW-1:0]  mem_addr,
  input  logic [DW-1:0]  mem_rdata,
  input  logic           mem_rvalid,
  output logic           busy,
  output logic           done,
  output logic [AW-1:0]  new_pc
);
  localparam int NOPS = 2;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  // state
  seq_state_e      state_q, state_d;
  read_step_e      step_q, step_d;
  logic            done_q, done_d;

  logic [OPW-1:0]  base_op_q, idx_op_q;
  logic [MW-1:0]   mask_q;
  logic            win_en_q;
  logic [AW-1:0]   win_base_q;
  logic [AW-1:0]   tbl_q, ptr_q, pc_q;
  logic [DW-1:0]   idx_byte_q, pc_lo_q;

  logic            accept, take;
  logic [OPW-1:0]  op_sel  [NOPS];
  logic [AW-1:0]   op_phys [NOPS];
  logic [AW-1:0]   dest;

  assign accept = (state_q == ST_IDLE) && start;
  assign take   = (state_q == ST_WAIT) && mem_rvalid;

  assign op_sel[0] = base_op_q;
  assign op_sel[1] = idx_op_q;

  generate
    for (genvar g = 0; g < NOPS; g++) begin : g_win
      tij_window #(.AW(AW), .OPW(OPW), .WIN_LO(WIN_LO)) u_win (
        .op       (op_sel[g]),
        .win_en   (win_en_q),
        .win_base (win_base_q),
        .phys     (op_phys[g])
      );
    end
  endgenerate

  tij_addr_calc #(.AW(AW), .MW(MW)) u_calc (
    .tbl_start (tbl_q),
    .idx_byte  (idx_byte_q),
    .mask      (mask_q),
    .dest      (dest)
  );

  // next state
  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start) begin
        state_d = ST_ISSUE;
        step_d  = RD_TBL_LO;
      end
      ST_ISSUE: state_d = ST_WAIT;
      ST_WAIT: if (mem_rvalid) begin
        if (step_q == RD_DEST_HI) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else begin
          state_d = ST_ISSUE;
          step_d  = read_step_e'(step_q + 3'd1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      state_q <= ST_IDLE;
      step_q  <= RD_TBL_LO;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      done_q  <= done_d;
    end
  end

  // operand capture, enabled by an accepted start only
  always_ff @(posedge clk) begin
    if (accept) begin
      base_op_q  <= base_op;
      idx_op_q   <= idx_op;
      mask_q     <= mask;
      win_en_q   <= win_en;
      win_base_q <= win_base;
    end
  end

  // read data capture, one enable per step
  always_ff @(posedge clk) begin
    if (take && step_q == RD_TBL_LO)  tbl_q[7:0]  <= mem_rdata;
    if (take && step_q == RD_TBL_HI)  tbl_q[15:8] <= mem_rdata;
    if (take && step_q == RD_PTR_LO)  ptr_q[7:0]  <= mem_rdata;
    if (take && step_q == RD_PTR_HI)  ptr_q[15:8] <= mem_rdata;
    if (take && step_q == RD_IDX)     idx_byte_q  <= mem_rdata;
    if (take && step_q == RD_DEST_LO) pc_lo_q     <= mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i)                           pc_q <= '0;
    else if (take && step_q == RD_DEST_HI) pc_q <= {mem_rdata, pc_lo_q};
  end

  // address select
  always_comb begin
    unique case (step_q)
      RD_TBL_LO:  mem_addr = op_phys[0];
      RD_TBL_HI:  mem_addr = op_phys[0] + AW'(1);
      RD_PTR_LO:  mem_addr = op_phys[1];
      RD_PTR_HI:  mem_addr = op_phys[1] + AW'(1);
      RD_IDX:     mem_addr = ptr_q;
      RD_DEST_LO: mem_addr = dest;
      RD_DEST_HI: mem_addr = dest + AW'(1);
      default:    mem_addr = '0;
    endcase
  end

  assign mem_rd = (state_q == ST_ISSUE);
  assign busy   = (state_q != ST_IDLE);
  assign done   = done_q;
  assign new_pc = pc_q;

  // checks
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n_i)
    !busy |-> !mem_rd);

  a_r2_single_issue: assert property (@(posedge clk) disable iff (!rst_n_i)
    mem_rd |=> !mem_rd);

  a_r11_wait_valid: assert property (@(posedge clk) disable iff (!rst_n_i)
    (busy && !mem_rd && !mem_rvalid) |=> !mem_rd);

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n_i)
    done |=> !done);

  a_r9_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n_i)
    done |-> !busy);

  a_r10_ops_held: assert property (@(posedge clk) disable iff (!rst_n_i)
    (busy && start) |=> ($stable(base_op_q) && $stable(idx_op_q) && $stable(mask_q)));
endmodule

// File: tb/tbl_jump_seq_test.sv
`timescale 1ns/1ps
module tbl_jump_seq_test;
  logic        clk, rst_n, start, win_en;
  logic [7:0]  base_op, idx_op;
  logic [6:0]  mask;
  logic [15:0] win_base;
  logic        mem_rd, mem_rvalid, busy, done;
  logic [15:0] mem_addr, new_pc;
  logic [7:0]  mem_rdata;

  int vectors = 0, errors = 0;
  int lat_cfg = 1;
  bit summary_done = 0;

  tbl_jump_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .base_op(base_op), .idx_op(idx_op),
    .mask(mask), .win_en(win_en), .win_base(win_base), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid),
    .busy(busy), .done(done), .new_pc(new_pc)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  // memory contents: five programmable bytes over a hashed background
  logic [15:0] ov_a [5];
  logic [7:0]  ov_d [5];

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    for (int i = 0; i < 5; i++) if (ov_a[i] == a) return ov_d[i];
    return (a[7:0] * 8'd5 + a[15:8]) ^ 8'h5A;
  endfunction

  // memory model with configurable latency
  int          cnt = 0;
  logic [15:0] paddr;
  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    mem_rdata  <= 8'h00;
    if (cnt > 0) begin
      cnt <= cnt - 1;
      if (cnt == 1) begin mem_rvalid <= 1'b1; mem_rdata <= mem_byte(paddr); end
    end else if (mem_rd) begin
      if (lat_cfg == 1) begin mem_rvalid <= 1'b1; mem_rdata <= mem_byte(mem_addr); end
      else begin cnt <= lat_cfg - 1; paddr <= mem_addr; end
    end
  end

  // read monitor
  logic [15:0] rd_log [8];
  int rd_n = 0, overlap = 0;
  bit outstanding = 0;
  always @(posedge clk) begin
    if (mem_rvalid) outstanding = 0;
    if (mem_rd) begin
      if (outstanding) overlap++;
      outstanding = 1;
      if (rd_n < 8) rd_log[rd_n] = mem_addr;
      rd_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] tphys(input logic [7:0] op, input logic en, input logic [15:0] wb);
    return (en && op >= 8'h80) ? wb + {8'h00, op - 8'h80} : {8'h00, op};
  endfunction

  task automatic run(input logic [7:0] bop, input logic [7:0] iop, input logic [6:0] msk,
                     input logic wen, input logic [15:0] wb, input logic [15:0] tword,
                     input logic [15:0] iptr, input logic [7:0] ibyte, input int l, input bit poke);
    logic [15:0] bph, iph, dst, exp_pc;
    logic [15:0] er [7];
    logic [6:0]  off;
    int cyc;
    bph = tphys(bop, wen, wb);
    iph = tphys(iop, wen, wb);
    ov_a[0] = bph;      ov_d[0] = tword[7:0];
    ov_a[1] = bph + 1;  ov_d[1] = tword[15:8];
    ov_a[2] = iph;      ov_d[2] = iptr[7:0];
    ov_a[3] = iph + 1;  ov_d[3] = iptr[15:8];
    ov_a[4] = iptr;     ov_d[4] = ibyte;
    off = ibyte[6:0] & msk;
    dst = tword + {8'h00, off, 1'b0};
    exp_pc = {mem_byte(dst + 16'd1), mem_byte(dst)};
    er[0] = bph; er[1] = bph + 1; er[2] = iph; er[3] = iph + 1;
    er[4] = iptr; er[5] = dst; er[6] = dst + 1;
    lat_cfg = l;
    rd_n = 0; overlap = 0;
    base_op = bop; idx_op = iop; mask = msk; win_en = wen; win_base = wb;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    base_op = ~bop; idx_op = ~iop; mask = ~msk; win_en = ~wen; win_base = ~wb;
    cyc = 1;
    chk(busy === 1'b1, "R9 busy after start", {31'd0, busy}, 1);
    while (done !== 1'b1 && cyc < 200) begin
      if (poke && cyc == 3) begin start = 1'b1; mask = 7'h00; end
      else start = 1'b0;
      @(negedge clk);
      cyc++;
      if (done !== 1'b1) chk(busy === 1'b1, "R9 busy held", {31'd0, busy}, 1);
    end
    start = 1'b0;
    chk(cyc == 7 * (l + 1) + 1, "R9 latency", cyc, 7 * (l + 1) + 1);
    chk(busy === 1'b0, "R9 idle with done", {31'd0, busy}, 0);
    chk(new_pc === exp_pc, "R7 new_pc", new_pc, exp_pc);
    for (int i = 0; i < 7; i++)
      chk(rd_log[i] === er[i], $sformatf("R2 read %0d (R3 R4 R6 R8)", i), rd_log[i], er[i]);
    @(negedge clk);
    chk(done === 1'b0, "R9 done single pulse", {31'd0, done}, 0);
    repeat (2) @(negedge clk);
    chk(rd_n == 7, "R10 read count", rd_n, 7);
    chk(overlap == 0, "R11 no issue while outstanding", overlap, 0);
  endtask

  initial begin
    for (int i = 0; i < 5; i++) begin ov_a[i] = 16'hFFFF; ov_d[i] = 8'h00; end
    rst_n = 0; start = 0; base_op = 0; idx_op = 0; mask = 0; win_en = 0; win_base = 0;
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && mem_rd === 1'b0, "R1 reset state",
        {29'd0, busy, done, mem_rd}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(busy === 1'b0 && mem_rd === 1'b0, "R1 idle after reset", {30'd0, busy, mem_rd}, 0);

    // R5: full mask sweep, index byte bit 7 set
    for (int m = 0; m < 128; m++)
      run(8'h20, 8'h30, 7'(m), 1'b0, 16'h0000, 16'h1234, 16'h0500, 8'hFF, 1, 1'b0);
    // R6 R8 R11: index byte sweep, table near top of space, latencies 1..3
    for (int b = 0; b < 256; b++)
      run(8'h40, 8'h50, 7'h7F, 1'b0, 16'h0000, 16'hFFF0, 16'h0600, 8'(b), 1 + (b % 3), 1'b0);
    // R3 R4: windowed operands, pointer that looks like a windowed register
    run(8'h85, 8'h90, 7'h3C, 1'b1, 16'h0300, 16'h2000, 16'h0090, 8'h2D, 1, 1'b0);
    run(8'h85, 8'h90, 7'h7F, 1'b1, 16'h0300, 16'h2000, 16'h00A4, 8'h81, 2, 1'b0);
    // R3: window enabled, operands below the window go direct
    run(8'h10, 8'h7F, 7'h0F, 1'b1, 16'h0300, 16'h4000, 16'h0700, 8'h37, 1, 1'b0);
    // R8: windowed operand at 0xFFFF, high byte wraps to 0x0000
    run(8'h81, 8'h20, 7'h05, 1'b1, 16'hFFFE, 16'hFFFE, 16'h0800, 8'h07, 1, 1'b0);
    // R10: start while busy ignored
    run(8'h22, 8'h33, 7'h55, 1'b0, 16'h0000, 16'h3000, 16'h0900, 8'h77, 1, 1'b1);
    run(8'h88, 8'h99, 7'h6A, 1'b1, 16'h1000, 16'h5000, 16'h0A00, 8'hEE, 3, 1'b1);

    if (!summary_done) begin
      summary_done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    end
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!summary_done) begin
      summary_done = 1;
      errors++;
      vectors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    end
    $finish;
  end
endmodule